// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block merges three ways of resetting a device into one internal reset, all timed in reference-clock cycles. The first is a power-on trigger: a supply-good level from an analog detector. The second is an external active-low reset pin. The third is a software reset requested through a control register on a small register bus. Each source has its own timing rules. A pin pulse that is too short is discarded. A software request counts only when the control bit is written low and then high again with enough cycles between the two writes.

While any reset is in progress, the block holds its output-enable low so that device pins go to high impedance. It raises a one-cycle register-initialise strobe at the start of each reset episode and reloads a small stub bank of configuration registers with their defaults. Software reads completion from bit 0 of the control register. A loopback register keeps its contents through power-on and pin resets and is cleared only by a software reset. The power-on trigger and the pin are first brought into the reference-clock domain through two-flop synchronisers.

Top module: `rstseq_top`

## Requirements
- R1: After the synchronous `rst` is released, with `pwr_good` low, `rst_busy` is 1 and `out_en` is 0, and they stay that way for as long as `pwr_good` is low.
- R2: The power-on reset lasts exactly POR_CYC (2048) cycles once the synchronised `pwr_good` is high. From the clock edge that first samples `pwr_good` high, `rst_busy` falls after the (POR_CYC+3)-th rising edge.
- R3: A low pulse on `ext_rst_n` lasting fewer than PIN_MIN (40) cycles has no effect. A pulse of PIN_MIN cycles or more starts a reset.
- R4: After an accepted, held pin reset is released, `rst_busy` falls after the (PIN_TAIL+3)-th rising edge following the release, with PIN_TAIL = 50.
- R5: The software reset bit is bit 0 of the control register at address 1. Writing 0 arms it. A later write of 1, made d cycles after the arming write, starts a reset when d >= SW_GAP (60) and does nothing when d < SW_GAP.
- R6: A software reset holds `rst_busy` for exactly SW_LEN (150) cycles. `rst_busy` falls SW_LEN+1 falling edges after the cycle of the write of 1. Once the reset is over, bit 0 of the control register reads 1.
- R7: `out_en` is 0 exactly when `rst_busy` is 1.
- R8: `reg_init` is high for exactly one cycle at the start of each reset episode.
- R9: The configuration registers at addresses 2 to 5 return to their defaults 8'h11, 8'h22, 8'h33 and 8'h44 after any reset.
- R10: The loopback register at address 12, also driven on `loop_mode`, keeps its value through power-on and pin resets and is cleared to 0 by a software reset.
- R11: While `rst_busy` is 1, bus writes are ignored and `bus_rdata` reads 0. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset of the block's own flops |
| pwr_good | input | 1 | Supply-good level from the power-on detector (asynchronous) |
| ext_rst_n | input | 1 | External reset pin, active low (asynchronous) |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| rst_busy | output | 1 | Internal reset active |
| out_en | output | 1 | Output enable; low puts device outputs in high impedance |
| reg_init | output | 1 | One-cycle register-initialise strobe |
| loop_mode | output | 8 | Contents of the loopback register |

## Verification
The assertions assume that `pwr_good` and `ext_rst_n` reach the sequencer only through its synchronisers. They also assume that a reset episode starts only from the run state. Under those assumptions, the pin counter can show acceptance only after a low sample, and a timed exit can come only from a counting state. The stimulus changes every asynchronous input on the falling clock edge and issues bus writes one cycle wide. It also waits for each episode to finish before it starts the next, so every measured duration begins from a known run state.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 4;

    typedef enum logic [2:0] {
        ST_POR_WAIT,
        ST_POR_CNT,
        ST_PIN_HOLD,
        ST_PIN_TAIL,
        ST_SW,
        ST_RUN
    } seq_state_e;

    typedef struct packed {
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } bus_req_t;

    function automatic logic [DATA_W-1:0] cfg_default(input int idx);
        return DATA_W'(8'h11 * (idx + 1));
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int               WIDTH   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1 <= RST_VAL[b];
                s2 <= RST_VAL[b];
            end else begin
                s1 <= d[b];
                s2 <= s1;
            end
        end
        assign q[b] = s2;
    end

endmodule

// File: rtl/rstseq_pin_filter.sv
module rstseq_pin_filter #(
    parameter int PIN_MIN = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_s,
    output logic pin_ok
);

    localparam int LW = $clog2(PIN_MIN + 1);

    logic [LW-1:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || pin_s) begin
            low_cnt <= '0;
        end else if (low_cnt != LW'(PIN_MIN)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign pin_ok = (low_cnt == LW'(PIN_MIN));

    // acceptance can only follow a low sample of the pin
    assert_pin_ok_low_R3: assert property (@(posedge clk) disable iff (rst)
        pin_ok |-> $past(!pin_s));

endmodule

// File: rtl/rstseq_sw_arm.sv
module rstseq_sw_arm #(
    parameter int SW_GAP = 60
) (
    input  logic clk,
    input  logic rst,
    input  logic busy,
    input  logic ctrl_wr,
    input  logic ctrl_bit,
    output logic sw_fire
);

    localparam int GW = $clog2(SW_GAP + 1);

    logic          armed;
    logic [GW-1:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            gap     <= '0;
            sw_fire <= 1'b0;
        end else begin
            sw_fire <= 1'b0;
            if (armed && gap != GW'(SW_GAP)) begin
                gap <= gap + 1'b1;
            end
            if (busy) begin
                armed <= 1'b0;
            end else if (ctrl_wr) begin
                if (!ctrl_bit) begin
                    armed <= 1'b1;
                    gap   <= GW'(1);
                end else begin
                    armed   <= 1'b0;
                    sw_fire <= armed && (gap >= GW'(SW_GAP));
                end
            end
        end
    end

    assert_fire_gap_R5: assert property (@(posedge clk) disable iff (rst)
        sw_fire |-> ($past(armed) && $past(gap) >= GW'(SW_GAP)));

endmodule

// File: rtl/rstseq_fsm.sv
module rstseq_fsm
    import rstseq_pkg::*;
#(
    parameter int POR_CYC  = 2048,
    parameter int PIN_TAIL = 50,
    parameter int SW_LEN   = 150
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_s,
    input  logic pin_s,
    input  logic pin_ok,
    input  logic sw_fire,
    output logic busy,
    output logic out_en,
    output logic reg_init,
    output logic sw_clear
);

    localparam int MAXC = max3(POR_CYC, PIN_TAIL, SW_LEN);
    localparam int CW   = $clog2(MAXC + 1);

    seq_state_e    state, state_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          busy_d;

    always_comb begin
        state_n = state;
        cnt_n   = '0;
        if (!pwr_s) begin
            state_n = ST_POR_WAIT;
        end else begin
            unique case (state)
                ST_POR_WAIT: state_n = ST_POR_CNT;
                ST_POR_CNT: begin
                    if (cnt == CW'(POR_CYC - 1)) state_n = ST_RUN;
                    else cnt_n = cnt + 1'b1;
                end
                ST_PIN_HOLD: begin
                    if (pin_s) state_n = ST_PIN_TAIL;
                end
                ST_PIN_TAIL: begin
                    if (pin_ok) state_n = ST_PIN_HOLD;
                    else if (cnt == CW'(PIN_TAIL - 1)) state_n = ST_RUN;
                    else cnt_n = cnt + 1'b1;
                end
                ST_SW: begin
                    if (pin_ok) state_n = ST_PIN_HOLD;
                    else if (cnt == CW'(SW_LEN - 1)) state_n = ST_RUN;
                    else cnt_n = cnt + 1'b1;
                end
                ST_RUN: begin
                    if (pin_ok) state_n = ST_PIN_HOLD;
                    else if (sw_fire) state_n = ST_SW;
                end
                default: state_n = ST_POR_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_POR_WAIT;
            cnt    <= '0;
            busy_d <= 1'b0;
        end else begin
            state  <= state_n;
            cnt    <= cnt_n;
            busy_d <= busy;
        end
    end

    assign busy     = (state != ST_RUN);
    assign out_en   = (state == ST_RUN);
    assign reg_init = busy && !busy_d;
    assign sw_clear = (state == ST_SW) && (cnt == '0);

    assert_por_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !pwr_s |=> (state == ST_POR_WAIT));

    assert_sw_bound_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SW) |-> (cnt < CW'(SW_LEN)));

    assert_timed_exit_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(out_en) |-> ($past(state) == ST_POR_CNT || $past(state) == ST_PIN_TAIL
                           || $past(state) == ST_SW));

    assert_init_pulse_R8: assert property (@(posedge clk) disable iff (rst)
        reg_init |=> !reg_init);

endmodule

// File: rtl/rstseq_regs.sv
module rstseq_regs
    import rstseq_pkg::*;
#(
    parameter int NCFG      = 4,
    parameter int CTRL_ADDR = 1,
    parameter int CFG_BASE  = 2,
    parameter int LOOP_ADDR = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              busy,
    input  logic              sw_clear,
    input  bus_req_t          req,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] loop_q
);

    logic [DATA_W-1:0] cfg_q [NCFG];
    logic [DATA_W-2:0] ctrl_q;
    logic              wr_ok;

    assign wr_ok = req.wr && !busy;

    for (genvar i = 0; i < NCFG; i++) begin : g_cfg
        always_ff @(posedge clk) begin
            if (rst || busy) begin
                cfg_q[i] <= cfg_default(i);
            end else if (wr_ok && req.addr == ADDR_W'(CFG_BASE + i)) begin
                cfg_q[i] <= req.wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || busy) begin
            ctrl_q <= '0;
        end else if (wr_ok && req.addr == ADDR_W'(CTRL_ADDR)) begin
            ctrl_q <= req.wdata[DATA_W-1:1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst || sw_clear) begin
            loop_q <= '0;
        end else if (wr_ok && req.addr == ADDR_W'(LOOP_ADDR)) begin
            loop_q <= req.wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (req.addr == ADDR_W'(CTRL_ADDR)) rdata = {ctrl_q, 1'b1};
        if (req.addr == ADDR_W'(LOOP_ADDR)) rdata = loop_q;
        for (int i = 0; i < NCFG; i++) begin
            if (req.addr == ADDR_W'(CFG_BASE + i)) rdata = cfg_q[i];
        end
        if (busy) rdata = '0;
    end

    assert_loop_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !sw_clear) |=> $stable(loop_q));

endmodule

// File: rtl/rstseq_top.sv
module rstseq_top
    import rstseq_pkg::*;
#(
    parameter int POR_CYC   = 2048,
    parameter int PIN_MIN   = 40,
    parameter int PIN_TAIL  = 50,
    parameter int SW_GAP    = 60,
    parameter int SW_LEN    = 150,
    parameter int NCFG      = 4,
    parameter int CTRL_ADDR = 1,
    parameter int CFG_BASE  = 2,
    parameter int LOOP_ADDR = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_good,
    input  logic              ext_rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rst_busy,
    output logic              out_en,
    output logic              reg_init,
    output logic [DATA_W-1:0] loop_mode
);

    logic [1:0] sync_q;
    logic       pwr_s, pin_s, pin_ok, sw_fire, busy, sw_clear, ctrl_wr;
    bus_req_t   req;

    rstseq_sync #(.WIDTH(2), .RST_VAL(2'b01)) u_sync (
        .clk(clk), .rst(rst), .d({pwr_good, ext_rst_n}), .q(sync_q)
    );
    assign pwr_s = sync_q[1];
    assign pin_s = sync_q[0];

    rstseq_pin_filter #(.PIN_MIN(PIN_MIN)) u_pin (
        .clk(clk), .rst(rst), .pin_s(pin_s), .pin_ok(pin_ok)
    );

    assign req     = '{wr: bus_wr, addr: bus_addr, wdata: bus_wdata};
    assign ctrl_wr = bus_wr && !busy && (bus_addr == ADDR_W'(CTRL_ADDR));

    rstseq_sw_arm #(.SW_GAP(SW_GAP)) u_arm (
        .clk(clk), .rst(rst), .busy(busy), .ctrl_wr(ctrl_wr),
        .ctrl_bit(bus_wdata[0]), .sw_fire(sw_fire)
    );

    rstseq_fsm #(.POR_CYC(POR_CYC), .PIN_TAIL(PIN_TAIL), .SW_LEN(SW_LEN)) u_fsm (
        .clk(clk), .rst(rst), .pwr_s(pwr_s), .pin_s(pin_s), .pin_ok(pin_ok),
        .sw_fire(sw_fire), .busy(busy), .out_en(out_en), .reg_init(reg_init),
        .sw_clear(sw_clear)
    );

    rstseq_regs #(.NCFG(NCFG), .CTRL_ADDR(CTRL_ADDR), .CFG_BASE(CFG_BASE),
                  .LOOP_ADDR(LOOP_ADDR)) u_regs (
        .clk(clk), .rst(rst), .busy(busy), .sw_clear(sw_clear), .req(req),
        .rdata(bus_rdata), .loop_q(loop_mode)
    );

    assign rst_busy = busy;

endmodule

// File: tb/test_rstseq_top.sv
module test_rstseq_top;

    localparam int POR_CYC = 2048, PIN_MIN = 40, PIN_TAIL = 50, SW_GAP = 60, SW_LEN = 150;

    logic       clk = 0, rst = 1, pwr_good = 0, ext_rst_n = 1, bus_wr = 0;
    logic [3:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0, bus_rdata, loop_mode;
    logic       rst_busy, out_en, reg_init;

    int total = 0, bad = 0, oe_bad = 0, init_cnt = 0;
    bit done = 0;

    rstseq_top i_rstseq_top (
        .clk(clk), .rst(rst), .pwr_good(pwr_good), .ext_rst_n(ext_rst_n),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .rst_busy(rst_busy), .out_en(out_en),
        .reg_init(reg_init), .loop_mode(loop_mode)
    );

    always #10 clk = ~clk;

    // R7 monitor and R8 pulse counter
    always @(negedge clk) begin
        if (!rst) begin
            if (out_en == rst_busy) oe_bad++;
            if (reg_init) init_cnt++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        do begin @(negedge clk); n++; end while (rst_busy && n < 5000);
    endtask

    task automatic settle();
        int n;
        wait_idle(n);
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        int n, saw, i0;
        repeat (3) @(negedge clk);
        rst = 0;
        repeat (20) @(negedge clk);
        // R1 reset state with supply low
        chk(rst_busy == 1 && out_en == 0, "R1", rst_busy, 1);
        rd(4'd1, v);
        chk(v == 0, "R11 read in reset", v, 0);
        // R2 power-on duration
        pwr_good = 1;
        wait_idle(n);
        chk(n == POR_CYC + 3, "R2", n, POR_CYC + 3);
        rd(4'd1, v);
        chk(v == 8'h01, "R6 status bit", v, 1);
        // R9 defaults and R11 unmapped
        for (int i = 0; i < 4; i++) begin
            rd(4'(2 + i), v);
            chk(v == 8'(8'h11 * (i + 1)), "R9 default", v, 8'h11 * (i + 1));
        end
        rd(4'd9, v);
        chk(v == 0, "R11 unmapped", v, 0);
        // R10 loop kept through power-on
        wr(4'd12, 8'hA5);
        wr(4'd3, 8'hF0);
        rd(4'd3, v);
        chk(v == 8'hF0, "R9 write", v, 8'hF0);
        init_cnt = 0;
        @(negedge clk); pwr_good = 0;
        repeat (10) @(negedge clk);
        wr(4'd12, 8'h3C);           // R11 ignored in reset
        pwr_good = 1;
        settle();
        chk(init_cnt == 1, "R8 por", init_cnt, 1);
        chk(loop_mode == 8'hA5, "R10 por", loop_mode, 8'hA5);
        rd(4'd3, v);
        chk(v == 8'h22, "R9 after por", v, 8'h22);
        // R3 pin width sweep around threshold
        for (int w = PIN_MIN - 8; w <= PIN_MIN + 8; w++) begin
            saw = 0;
            ext_rst_n = 0;
            for (int c = 0; c < w; c++) begin @(negedge clk); if (rst_busy) saw = 1; end
            ext_rst_n = 1;
            for (int c = 0; c < 8; c++) begin @(negedge clk); if (rst_busy) saw = 1; end
            chk(saw == (w >= PIN_MIN), "R3", saw, w >= PIN_MIN);
            settle();
        end
        // R4 pin tail, R10 loop kept, R8 pulse
        init_cnt = 0;
        wr(4'd4, 8'h00);
        ext_rst_n = 0;
        repeat (100) @(negedge clk);
        ext_rst_n = 1;
        wait_idle(n);
        chk(n == PIN_TAIL + 3, "R4", n, PIN_TAIL + 3);
        chk(init_cnt == 1, "R8 pin", init_cnt, 1);
        chk(loop_mode == 8'hA5, "R10 pin", loop_mode, 8'hA5);
        rd(4'd4, v);
        chk(v == 8'h33, "R9 after pin", v, 8'h33);
        // R5 gap sweep, R6 duration
        for (int d = SW_GAP - 6; d <= SW_GAP + 6; d++) begin
            wr(4'd12, 8'(d));
            i0 = init_cnt;
            wr(4'd1, 8'h00);
            repeat (d - 1) @(negedge clk);
            wr(4'd1, 8'h01);
            wait_idle(n);
            if (d >= SW_GAP) begin
                chk(n == SW_LEN + 1, "R6", n, SW_LEN + 1);
                chk(loop_mode == 0, "R10 sw", loop_mode, 0);
                chk(init_cnt == i0 + 1, "R8 sw", init_cnt - i0, 1);
            end else begin
                chk(n == 1, "R5 short gap", n, 1);
                chk(loop_mode == 8'(d), "R5 no reset", loop_mode, d);
            end
            repeat (4) @(negedge clk);
        end
        rd(4'd1, v);
        chk(v == 8'h01, "R6 status after", v, 1);
        chk(oe_bad == 0, "R7", oe_bad, 0);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule